// File: doc/BRIEF.md
# Instruction-Cache Invalidate Trap Arbiter

This block sits beside the system-instruction decode of a processor core. It handles one instruction: the one that invalidates instruction-cache lines, chosen by address, out to the point of unification. Each request carries its five system-encoding fields, the current exception level and a 64-bit virtual address. The block first checks whether the encoding names this instruction. If it does, the block resolves a fixed priority chain over the control state. That state covers the user cache-op enables at level 1 and level 2, the hypervisor trap bits, host mode, the trap-general flag, a fine-grained trap bit with its level-3 gate, the feature-present flags and the implementation's NOP hints.

Exactly one outcome comes out, one cycle after the request. The possible outcomes are: undefined, execute as NOP, trap to level 1, trap to level 2, or execute. Each trap carries an exception class. An execute outcome also places the address and a point-of-unification scope tag on a valid/ready request towards the cache. The cache, address translation and fault generation sit outside this block.

Top module: `icinv_trap_arbiter`

## Requirements
- R1: A request is accepted only when op0=2'b01, op1=3'b011, crn=4'b0111, crm=4'b0101 and op2=3'b001. For a request that does not match, `res_valid` stays low in the following cycle and `res_code` keeps its previous value.
- R2: When `feat_base` is 0, an accepted request gives UNDEF at every exception level, whatever the other controls are.
- R3: At levels 0, 1 and 2, if `impl_nop`=1 and `impl_can_trap`=0, the outcome is NOP, ahead of every trap check.
- R4: At level 0, outside host mode, with `el1_user_cmo_en`=0, the block traps. The trap goes to level 2 when `el2_enabled`=1 and `hyp_trap_general`=1. Otherwise it goes to level 1. This check comes before every hypervisor trap bit.
- R5: At level 1, and at level 0 outside host mode, three bits are checked in this order: `hyp_trap_pou`, then `hyp_trap_cou`, then the gated fine-grained trap. Each of them traps to level 2, and only when `el2_enabled`=1.
- R6: The fine-grained trap applies only when `feat_fgt`=1, `fgt_inv_trap`=1, and either `has_el3`=0 or `el3_fgt_enable`=1.
- R7: At level 0 in host mode, `el1_user_cmo_en` and the hypervisor trap bits have no effect. The block traps to level 2 when `el2_user_cmo_en`=0.
- R8: At levels 2 and 3 the only outcomes are NOP (when `impl_nop`=1) and EXEC. At level 3, `impl_can_trap` has no effect.
- R9: `res_ec` is 0x18 on both trap outcomes and 0 on every other outcome.
- R10: `res_valid` is high for exactly the one cycle after an accepted request. `res_code` is one-hot with bit0=UNDEF, bit1=NOP, bit2=TRAP_EL1, bit3=TRAP_EL2 and bit4=EXEC, and it is 0 after reset.
- R11: On EXEC, `inv_valid` rises in the same cycle as `res_valid`, with `inv_addr` equal to the request address (at any alignment) and `inv_scope_pou`=1. These stay stable until the cycle after a cycle in which `inv_ready` is high. The requester issues no further EXEC while `inv_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_addr | input | 64 | Virtual address operand |
| cur_el | input | 2 | Current exception level |
| feat_base | input | 1 | 64-bit execution state implemented |
| feat_fgt | input | 1 | Fine-grained trap feature implemented |
| has_el3 | input | 1 | Level 3 implemented |
| el2_enabled | input | 1 | Level 2 enabled in the current state |
| in_host | input | 1 | Level 0 runs under a host hypervisor |
| el1_user_cmo_en | input | 1 | Level-1 control: user cache ops allowed |
| el2_user_cmo_en | input | 1 | Level-2 control: user cache ops allowed (host mode) |
| hyp_trap_pou | input | 1 | Hypervisor trap for point-of-unification ops |
| hyp_trap_cou | input | 1 | Hypervisor trap for cache-to-unification ops |
| hyp_trap_general | input | 1 | Hypervisor trap-general routing flag |
| fgt_inv_trap | input | 1 | Fine-grained trap bit for this invalidate |
| el3_fgt_enable | input | 1 | Level-3 enable for fine-grained traps |
| impl_nop | input | 1 | Implementation treats the op as a NOP |
| impl_can_trap | input | 1 | Implementation can still trap the op |
| res_valid | output | 1 | Outcome valid pulse |
| res_code | output | 5 | One-hot outcome |
| res_ec | output | 6 | Exception class for traps |
| inv_valid | output | 1 | Invalidate request to the cache |
| inv_ready | input | 1 | Cache accepts the request |
| inv_addr | output | 64 | Address to invalidate |
| inv_scope_pou | output | 1 | Scope tag: point of unification |

## Verification
The bench builds the block with its default parameters. These are a 64-bit address, a 6-bit exception class of 0x18, and the standard encoding constants, so every mismatch test varies one of the real fields. The full address width lets the bench pass unaligned addresses with the upper bits set through to the cache interface. Each priority pairing in the chain is driven with two competing controls set, so that the check shows which of them wins.

// File: rtl/icinv_pkg.sv
// Package: shared outcome type and control bundle for the invalidate
// trap arbiter. Assumes the outcome order below matches the one-hot bit
// positions published on res_code.
package icinv_pkg;

    // Outcome enumeration; value = one-hot bit index on res_code.
    typedef enum logic [2:0] {
        OUT_UNDEF = 3'd0,
        OUT_NOP   = 3'd1,
        OUT_TRAP1 = 3'd2,
        OUT_TRAP2 = 3'd3,
        OUT_EXEC  = 3'd4
    } outcome_e;

    localparam int unsigned OUTCOME_N = 5;

    // Control bundle gathered from the port list.
    typedef struct packed {
        logic feat_base;
        logic feat_fgt;
        logic has_el3;
        logic el2_enabled;
        logic in_host;
        logic el1_user_cmo_en;
        logic el2_user_cmo_en;
        logic hyp_trap_pou;
        logic hyp_trap_cou;
        logic hyp_trap_general;
        logic fgt_inv_trap;
        logic el3_fgt_enable;
        logic impl_nop;
        logic impl_can_trap;
    } ctl_t;

    // True for the two trap outcomes.
    function automatic logic is_trap(outcome_e o);
        return (o == OUT_TRAP1) || (o == OUT_TRAP2);
    endfunction

endpackage

// File: rtl/icinv_enc_match.sv
// Module: compares the five system-encoding fields of a request with the
// constants of the invalidate instruction. Purely combinational; assumes
// the caller qualifies the hit with its own valid strobe.
module icinv_enc_match #(
    parameter int unsigned OP0_W = 2,
    parameter int unsigned OP1_W = 3,
    parameter int unsigned CRN_W = 4,
    parameter int unsigned CRM_W = 4,
    parameter int unsigned OP2_W = 3,
    parameter logic [OP0_W-1:0] OP0_V = 2'b01,
    parameter logic [OP1_W-1:0] OP1_V = 3'b011,
    parameter logic [CRN_W-1:0] CRN_V = 4'b0111,
    parameter logic [CRM_W-1:0] CRM_V = 4'b0101,
    parameter logic [OP2_W-1:0] OP2_V = 3'b001
) (
    input  logic [OP0_W-1:0] op0,
    input  logic [OP1_W-1:0] op1,
    input  logic [CRN_W-1:0] crn,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output logic             hit
);
    localparam int unsigned FIELDS = 5;

    logic [FIELDS-1:0] field_eq;

    // Per-field equality, then all fields must agree.
    always_comb begin
        field_eq[0] = (op0 == OP0_V);
        field_eq[1] = (op1 == OP1_V);
        field_eq[2] = (crn == CRN_V);
        field_eq[3] = (crm == CRM_V);
        field_eq[4] = (op2 == OP2_V);
        hit         = &field_eq;
    end

endmodule

// File: rtl/icinv_policy.sv
// Module: the per-level priority chain that picks one outcome for an
// accepted invalidate. Combinational; the clock and reset serve only the
// checks placed beside the chain. Assumes the controls are stable in the
// cycle the request is sampled.
module icinv_policy
    import icinv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [1:0] el,
    input  ctl_t      ctl,
    output outcome_e  outc
);
    logic nop_locked;     // NOP that no trap may override
    logic fgt_live;       // fine-grained trap armed and gated on
    logic hyp_live;       // hypervisor traps can apply in this context
    outcome_e tail;       // result once every trap check is passed

    // Derived conditions shared by the level branches.
    always_comb begin
        nop_locked = ctl.impl_nop & ~ctl.impl_can_trap;
        fgt_live   = ctl.feat_fgt & ctl.fgt_inv_trap &
                     (~ctl.has_el3 | ctl.el3_fgt_enable);
        hyp_live   = ctl.el2_enabled;
        tail       = ctl.impl_nop ? OUT_NOP : OUT_EXEC;
    end

    // Fixed priority chain, one branch per exception level.
    always_comb begin
        outc = tail;
        if (!ctl.feat_base) begin
            outc = OUT_UNDEF;
        end else begin
            unique case (el)
                2'd0: begin
                    if (nop_locked)
                        outc = OUT_NOP;
                    else if (!ctl.in_host && !ctl.el1_user_cmo_en)
                        outc = (ctl.el2_enabled && ctl.hyp_trap_general) ? OUT_TRAP2 : OUT_TRAP1;
                    else if (hyp_live && !ctl.in_host && ctl.hyp_trap_pou)
                        outc = OUT_TRAP2;
                    else if (hyp_live && !ctl.in_host && ctl.hyp_trap_cou)
                        outc = OUT_TRAP2;
                    else if (hyp_live && !ctl.in_host && fgt_live)
                        outc = OUT_TRAP2;
                    else if (ctl.in_host && !ctl.el2_user_cmo_en)
                        outc = OUT_TRAP2;
                    else
                        outc = tail;
                end
                2'd1: begin
                    if (nop_locked)
                        outc = OUT_NOP;
                    else if (hyp_live && ctl.hyp_trap_pou)
                        outc = OUT_TRAP2;
                    else if (hyp_live && ctl.hyp_trap_cou)
                        outc = OUT_TRAP2;
                    else if (hyp_live && fgt_live)
                        outc = OUT_TRAP2;
                    else
                        outc = tail;
                end
                2'd2: begin
                    if (nop_locked)
                        outc = OUT_NOP;
                    else
                        outc = tail;
                end
                default: begin
                    outc = tail;
                end
            endcase
        end
    end

    // R2: a missing base feature always yields UNDEF.
    assert_undef_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.feat_base) |-> (outc == OUT_UNDEF));

    // R3: an untrappable NOP hint wins at every level once the feature exists.
    assert_nop_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.feat_base && ctl.impl_nop && !ctl.impl_can_trap) |-> (outc == OUT_NOP));

    // R8: upper levels never trap.
    assert_high_el_no_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.feat_base && el[1]) |-> (outc == OUT_NOP || outc == OUT_EXEC));

    // R5: without level 2 enabled, level 1 never traps.
    assert_no_el2_no_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (el == 2'd1 && !ctl.el2_enabled) |-> !is_trap(outc));

endmodule

// File: rtl/icinv_result_reg.sv
// Module: registers the chosen outcome as a one-hot code with its
// exception class and a one-cycle valid pulse. Holds the last code when
// nothing is accepted. Assumes outc is meaningful whenever accept is high.
module icinv_result_reg
    import icinv_pkg::*;
#(
    parameter int unsigned        EC_W    = 6,
    parameter logic [EC_W-1:0]    TRAP_EC = 6'h18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  outcome_e              outc,
    output logic                  res_valid,
    output logic [OUTCOME_N-1:0]  res_code,
    output logic [EC_W-1:0]       res_ec
);
    logic [OUTCOME_N-1:0] code_next;

    // One-hot expansion of the outcome index.
    generate
        for (genvar gi = 0; gi < OUTCOME_N; gi++) begin : g_onehot
            assign code_next[gi] = (outc == outcome_e'(gi));
        end
    endgenerate

    // Capture the outcome on accept; otherwise drop valid and hold the code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= '0;
            res_ec    <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_code <= code_next;
                res_ec   <= is_trap(outc) ? TRAP_EC : '0;
            end
        end
    end

    // R10: a published outcome is exactly one-hot.
    assert_onehot_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(res_code) == 1));

    // R9: the class is nonzero exactly on the trap bits.
    assert_ec_on_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_ec == TRAP_EC) == (res_code[2] | res_code[3])) &&
                      ((res_ec == '0) == !(res_code[2] | res_code[3])));

endmodule

// File: rtl/icinv_cache_req.sv
// Module: holds the invalidate address and scope towards the cache under
// a valid/ready handshake. Assumes no new start arrives while a request is
// still pending.
module icinv_cache_req #(
    parameter int unsigned ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic [ADDR_W-1:0] inv_addr,
    output logic              inv_scope_pou
);
    // Load on start, clear once the cache takes the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_valid <= 1'b0;
            inv_addr  <= '0;
        end else if (start) begin
            inv_valid <= 1'b1;
            inv_addr  <= addr;
        end else if (inv_valid && inv_ready) begin
            inv_valid <= 1'b0;
        end
    end

    // Every request from this block targets the point of unification.
    assign inv_scope_pou = 1'b1;

    // R11: a stalled request keeps its address and stays valid.
    assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_addr)));

    // R11: the requester must not start another while one is pending.
    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |-> !start);

endmodule

// File: rtl/icinv_trap_arbiter.sv
// Module (top): arbiter for the instruction-cache invalidate-by-address
// system instruction. Matches the encoding, runs the level priority chain,
// registers the outcome and forwards execute requests to the cache.
// Assumes synchronous active-low reset and controls stable with the request.
module icinv_trap_arbiter
    import icinv_pkg::*;
#(
    parameter int unsigned     ADDR_W  = 64,
    parameter int unsigned     EC_W    = 6,
    parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_op0,
    input  logic [2:0]           req_op1,
    input  logic [3:0]           req_crn,
    input  logic [3:0]           req_crm,
    input  logic [2:0]           req_op2,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           cur_el,
    input  logic                 feat_base,
    input  logic                 feat_fgt,
    input  logic                 has_el3,
    input  logic                 el2_enabled,
    input  logic                 in_host,
    input  logic                 el1_user_cmo_en,
    input  logic                 el2_user_cmo_en,
    input  logic                 hyp_trap_pou,
    input  logic                 hyp_trap_cou,
    input  logic                 hyp_trap_general,
    input  logic                 fgt_inv_trap,
    input  logic                 el3_fgt_enable,
    input  logic                 impl_nop,
    input  logic                 impl_can_trap,
    output logic                 res_valid,
    output logic [OUTCOME_N-1:0] res_code,
    output logic [EC_W-1:0]      res_ec,
    output logic                 inv_valid,
    input  logic                 inv_ready,
    output logic [ADDR_W-1:0]    inv_addr,
    output logic                 inv_scope_pou
);
    logic     enc_hit;
    logic     accept;
    logic     exec_start;
    ctl_t     ctl;
    outcome_e outc;

    // Gather the control ports into one bundle.
    always_comb begin
        ctl.feat_base        = feat_base;
        ctl.feat_fgt         = feat_fgt;
        ctl.has_el3          = has_el3;
        ctl.el2_enabled      = el2_enabled;
        ctl.in_host          = in_host;
        ctl.el1_user_cmo_en  = el1_user_cmo_en;
        ctl.el2_user_cmo_en  = el2_user_cmo_en;
        ctl.hyp_trap_pou     = hyp_trap_pou;
        ctl.hyp_trap_cou     = hyp_trap_cou;
        ctl.hyp_trap_general = hyp_trap_general;
        ctl.fgt_inv_trap     = fgt_inv_trap;
        ctl.el3_fgt_enable   = el3_fgt_enable;
        ctl.impl_nop         = impl_nop;
        ctl.impl_can_trap    = impl_can_trap;
    end

    icinv_enc_match u_match (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (enc_hit)
    );

    icinv_policy u_policy (
        .clk   (clk),
        .rst_n (rst_n),
        .el    (cur_el),
        .ctl   (ctl),
        .outc  (outc)
    );

    // Qualify the request and pick out execute outcomes.
    assign accept     = req_valid & enc_hit;
    assign exec_start = accept & (outc == OUT_EXEC);

    icinv_result_reg #(
        .EC_W    (EC_W),
        .TRAP_EC (TRAP_EC)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .outc      (outc),
        .res_valid (res_valid),
        .res_code  (res_code),
        .res_ec    (res_ec)
    );

    icinv_cache_req #(
        .ADDR_W (ADDR_W)
    ) u_cache (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (exec_start),
        .addr          (req_addr),
        .inv_valid     (inv_valid),
        .inv_ready     (inv_ready),
        .inv_addr      (inv_addr),
        .inv_scope_pou (inv_scope_pou)
    );

    // R1: a non-matching request publishes nothing and keeps the old code.
    assert_mismatch_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !enc_hit) |=> (!res_valid && $stable(res_code)));

    // R11: the cache request rises together with an EXEC outcome.
    assert_exec_pairs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code[4]) |-> inv_valid);

endmodule

// File: tb/sim_icinv_trap_arbiter.sv
module sim_icinv_trap_arbiter;
    localparam logic [4:0] C_UNDEF = 5'b00001;
    localparam logic [4:0] C_NOP   = 5'b00010;
    localparam logic [4:0] C_T1    = 5'b00100;
    localparam logic [4:0] C_T2    = 5'b01000;
    localparam logic [4:0] C_EXEC  = 5'b10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op0 = 2'b01;
    logic [2:0] req_op1 = 3'b011;
    logic [3:0] req_crn = 4'b0111;
    logic [3:0] req_crm = 4'b0101;
    logic [2:0] req_op2 = 3'b001;
    logic [63:0] req_addr = '0;
    logic [1:0] cur_el = 2'd0;
    logic feat_base, feat_fgt, has_el3, el2_enabled, in_host;
    logic el1_user_cmo_en, el2_user_cmo_en, hyp_trap_pou, hyp_trap_cou;
    logic hyp_trap_general, fgt_inv_trap, el3_fgt_enable, impl_nop, impl_can_trap;
    logic res_valid;
    logic [4:0] res_code;
    logic [5:0] res_ec;
    logic inv_valid;
    logic inv_ready = 1'b0;
    logic [63:0] inv_addr;
    logic inv_scope_pou;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    icinv_trap_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
        .req_crm(req_crm), .req_op2(req_op2), .req_addr(req_addr),
        .cur_el(cur_el), .feat_base(feat_base), .feat_fgt(feat_fgt),
        .has_el3(has_el3), .el2_enabled(el2_enabled), .in_host(in_host),
        .el1_user_cmo_en(el1_user_cmo_en), .el2_user_cmo_en(el2_user_cmo_en),
        .hyp_trap_pou(hyp_trap_pou), .hyp_trap_cou(hyp_trap_cou),
        .hyp_trap_general(hyp_trap_general), .fgt_inv_trap(fgt_inv_trap),
        .el3_fgt_enable(el3_fgt_enable), .impl_nop(impl_nop),
        .impl_can_trap(impl_can_trap), .res_valid(res_valid),
        .res_code(res_code), .res_ec(res_ec), .inv_valid(inv_valid),
        .inv_ready(inv_ready), .inv_addr(inv_addr), .inv_scope_pou(inv_scope_pou)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Permissive baseline: feature present, everything allowed, no traps.
    task automatic defaults();
        feat_base = 1; feat_fgt = 0; has_el3 = 1; el2_enabled = 1; in_host = 0;
        el1_user_cmo_en = 1; el2_user_cmo_en = 1; hyp_trap_pou = 0; hyp_trap_cou = 0;
        hyp_trap_general = 0; fgt_inv_trap = 0; el3_fgt_enable = 0;
        impl_nop = 0; impl_can_trap = 0;
        req_op0 = 2'b01; req_op1 = 3'b011; req_crn = 4'b0111; req_crm = 4'b0101; req_op2 = 3'b001;
    endtask

    // Issue a matching request and check the outcome pulse, class and handshake.
    task automatic issue(input logic [1:0] el, input logic [63:0] a, input logic [4:0] exp, input string tag);
        logic [5:0] exp_ec;
        exp_ec = (exp == C_T1 || exp == C_T2) ? 6'h18 : 6'h00;
        @(negedge clk);
        cur_el = el; req_addr = a; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(res_valid == 1'b1, {tag, " R10 valid pulse"}, 64'(res_valid), 64'd1);
        chk(res_code == exp, {tag, " code"}, 64'(res_code), 64'(exp));
        chk(res_ec == exp_ec, {tag, " R9 class"}, 64'(res_ec), 64'(exp_ec));
        if (exp == C_EXEC) begin
            chk(inv_valid && inv_scope_pou && inv_addr == a, {tag, " R11 request"}, inv_addr, a);
            inv_ready = 1;
            @(negedge clk);
            inv_ready = 0;
            chk(inv_valid == 1'b0, {tag, " R11 retire"}, 64'(inv_valid), 64'd0);
        end else begin
            chk(inv_valid == 1'b0, {tag, " R11 no request"}, 64'(inv_valid), 64'd0);
            @(negedge clk);
        end
        chk(res_valid == 1'b0, {tag, " R10 pulse ends"}, 64'(res_valid), 64'd0);
    endtask

    task automatic t_reset();
        chk(res_valid == 0 && inv_valid == 0, "reset R10 valid low", 64'({res_valid, inv_valid}), 64'd0);
        chk(res_code == 5'b0, "reset R10 code zero", 64'(res_code), 64'd0);
    endtask

    // Mismatch: one field off, no pulse, code kept.
    task automatic mismatch(input int field, input logic [4:0] held);
        @(negedge clk);
        defaults();
        feat_base = 0;
        case (field)
            0: req_op0 = 2'b11;
            1: req_op1 = 3'b000;
            2: req_crn = 4'b0110;
            3: req_crm = 4'b0001;
            default: req_op2 = 3'b000;
        endcase
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(res_valid == 1'b0, "R1 mismatch no pulse", 64'(res_valid), 64'd0);
        chk(res_code == held, "R1 mismatch code held", 64'(res_code), 64'(held));
        defaults();
    endtask

    task automatic t_match();
        defaults(); impl_nop = 1;
        issue(2'd1, 64'h10, C_NOP, "R1 match");
        for (int f = 0; f < 5; f++) mismatch(f, C_NOP);
    endtask

    task automatic t_undef();
        defaults(); feat_base = 0;
        issue(2'd1, 64'h20, C_UNDEF, "R2 el1");
        defaults(); feat_base = 0; impl_nop = 1; el1_user_cmo_en = 0;
        issue(2'd0, 64'h24, C_UNDEF, "R2 el0");
        defaults(); feat_base = 0; impl_nop = 1;
        issue(2'd3, 64'h28, C_UNDEF, "R2 el3");
    endtask

    task automatic t_nop_first();
        defaults(); impl_nop = 1; hyp_trap_pou = 1;
        issue(2'd1, 64'h30, C_NOP, "R3 el1 nop over trap");
        defaults(); impl_nop = 1; el1_user_cmo_en = 0;
        issue(2'd0, 64'h34, C_NOP, "R3 el0 nop over uci");
        defaults(); impl_nop = 1; impl_can_trap = 1; hyp_trap_pou = 1;
        issue(2'd1, 64'h38, C_T2, "R3 trappable nop yields trap");
        defaults(); impl_nop = 1; impl_can_trap = 1;
        issue(2'd1, 64'h3c, C_NOP, "R3 trappable nop no trap");
    endtask

    task automatic t_el0_uci();
        defaults(); el1_user_cmo_en = 0; hyp_trap_general = 1;
        issue(2'd0, 64'h40, C_T2, "R4 tge routes el2");
        defaults(); el1_user_cmo_en = 0;
        issue(2'd0, 64'h44, C_T1, "R4 to el1");
        defaults(); el1_user_cmo_en = 0; hyp_trap_general = 1; el2_enabled = 0;
        issue(2'd0, 64'h48, C_T1, "R4 el2 off to el1");
        defaults(); el1_user_cmo_en = 0; hyp_trap_pou = 1;
        issue(2'd0, 64'h4c, C_T1, "R4 uci before hyp bits");
    endtask

    task automatic t_hyp_chain();
        defaults(); hyp_trap_pou = 1;
        issue(2'd1, 64'h50, C_T2, "R5 pou el1");
        defaults(); hyp_trap_cou = 1;
        issue(2'd1, 64'h54, C_T2, "R5 cou el1");
        defaults(); hyp_trap_cou = 1;
        issue(2'd0, 64'h58, C_T2, "R5 cou el0");
        defaults(); hyp_trap_pou = 1; hyp_trap_cou = 1; el2_enabled = 0;
        issue(2'd1, 64'h5c, C_EXEC, "R5 el2 off no trap");
    endtask

    task automatic t_fgt_gate();
        defaults(); fgt_inv_trap = 1;
        issue(2'd1, 64'h60, C_EXEC, "R6 feature absent");
        defaults(); fgt_inv_trap = 1; feat_fgt = 1;
        issue(2'd1, 64'h64, C_EXEC, "R6 el3 gate off");
        defaults(); fgt_inv_trap = 1; feat_fgt = 1; el3_fgt_enable = 1;
        issue(2'd1, 64'h68, C_T2, "R6 el3 gate on");
        defaults(); fgt_inv_trap = 1; feat_fgt = 1; has_el3 = 0;
        issue(2'd0, 64'h6c, C_T2, "R6 no el3");
    endtask

    task automatic t_host();
        defaults(); in_host = 1; el2_user_cmo_en = 0;
        issue(2'd0, 64'h70, C_T2, "R7 host uci2");
        defaults(); in_host = 1; el1_user_cmo_en = 0; hyp_trap_pou = 1; hyp_trap_cou = 1;
        issue(2'd0, 64'h74, C_EXEC, "R7 host ignores el1 and hyp");
    endtask

    task automatic t_high_el();
        defaults(); hyp_trap_pou = 1; hyp_trap_cou = 1; el1_user_cmo_en = 0;
        el2_user_cmo_en = 0; feat_fgt = 1; fgt_inv_trap = 1; el3_fgt_enable = 1;
        issue(2'd2, 64'h80, C_EXEC, "R8 el2 exec");
        defaults(); impl_nop = 1; impl_can_trap = 1;
        issue(2'd2, 64'h84, C_NOP, "R8 el2 nop");
        defaults(); impl_nop = 1; impl_can_trap = 1; hyp_trap_pou = 1;
        issue(2'd3, 64'h88, C_NOP, "R8 el3 nop");
        defaults();
        issue(2'd3, 64'h8c, C_EXEC, "R8 el3 exec");
    endtask

    task automatic t_exec_hs();
        logic [63:0] a;
        a = 64'hFFFF_0000_1234_5677;
        defaults();
        @(negedge clk);
        cur_el = 2'd1; req_addr = a; req_valid = 1;
        @(negedge clk);
        req_valid = 0; req_addr = '0;
        chk(res_code == C_EXEC && inv_valid, "R11 exec raises request", 64'(res_code), 64'(C_EXEC));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(inv_valid && inv_addr == a && inv_scope_pou, "R11 stall holds", inv_addr, a);
        end
        inv_ready = 1;
        @(negedge clk);
        inv_ready = 0;
        chk(inv_valid == 1'b0, "R11 released", 64'(inv_valid), 64'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_match();
        t_undef();
        t_nop_first();
        t_el0_uci();
        t_hyp_chain();
        t_fgt_gate();
        t_host();
        t_high_el();
        t_exec_hs();
        finish_run();
    end
endmodule